// File: doc/BRIEF.md
# Debug Bus Read Access Engine

This block is a bus master driven by an external debug port. A debug host programs an address register and a control word. The control word carries an access size, a transfer count and a start bit. The engine then requests the system bus and waits for grant. It performs a single read, a block of reads paced by the host, or a four-beat doubleword burst. It places the returned data where the host can fetch it through the data register index.

The host learns about progress in only three ways: a one-cycle ready output, a data-valid status bit and an error status bit. In a paced block, ready pulses after each word, and the next read waits until the host has fetched the current word. Data-valid rises only after the last word. In a burst, all four beats land in a small buffer. Ready and data-valid then signal once, at the end. Reading the data index four times returns the beats in order.

Top module: `dbg_rd_engine`

## Requirements
- R1: After reset, ready_o and bus_req_o are low, and the control/status and address registers read as zero.
- R2: A count of 0 or 1 performs exactly one bus read. When that read completes without error, ready_o pulses for one cycle and data-valid is set. The data is then readable at register index 0xA.
- R3: The size field codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. Every completed read adds that byte count to the address register and decrements the count field, which saturates at zero.
- R4: With a count above 1 and no burst, ready_o pulses after every completed read. Data-valid stays clear until the read that brings the count to zero, and is set with it.
- R5: In a paced block, the engine holds bus_req_o low after each word until the host reads register index 0xA. That read releases the next request.
- R6: A count of 4 with size code 3 selects a burst. All four beats complete under one grant with bus_burst_o high, and the address advances 8 per beat. Ready_o and data-valid signal exactly once, after the fourth beat. Four reads of index 0xA return the beats in address order.
- R7: A bus error response sets the error bit and ends the sequence with bus_req_o low, data-valid clear and no ready pulse. A later start clears both error and data-valid.
- R8: bus_req_o stays high until bus_gnt_i arrives, and no data is taken before grant.
- R9: Writes to the control or address register are ignored while a sequence is in progress, including the hold between paced words.
- R10: Register map. Index 0x7 is control/status: bit0 is start on write and busy on read, bits 2:1 are size, bits 15:8 are count, bit16 is data-valid and bit17 is error. Index 0x9 is the address. Index 0xA is the data. Any other index reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_idx_i | input | 4 | Host register index |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_rd_i | input | 1 | Host register read strobe (advances data reads) |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 64 | Host read data for reg_idx_i (combinational) |
| ready_o | output | 1 | One-cycle ready pulse |
| bus_req_o | output | 1 | System bus request |
| bus_gnt_i | input | 1 | System bus grant |
| bus_addr_o | output | 32 | Read address |
| bus_size_o | output | 2 | Access size code |
| bus_burst_o | output | 1 | Burst transfer in progress |
| bus_rvalid_i | input | 1 | Read beat valid |
| bus_rdata_i | input | 64 | Read beat data |
| bus_err_i | input | 1 | Error response with the beat |

## Verification
A start write takes effect at the next clock edge, and bus_req_o rises in that same cycle. The engine accepts a beat on the edge where bus_rvalid_i is high. Ready_o, data-valid, the address step and the count step all become visible in the cycle after that edge. A host read of index 0xA releases the next paced request on the edge where the strobe is high. The bench drives inputs on falling edges, samples outputs on falling edges, and counts ready pulses a fixed delay after rising edges. It waits for the ready pulse before it reads status, and it checks that no request and no ready appear during holds and after errors.

// File: rtl/dbg_rd_pkg.sv
package dbg_rd_pkg;
  localparam logic [3:0] IDX_CTRL = 4'h7;
  localparam logic [3:0] IDX_ADDR = 4'h9;
  localparam logic [3:0] IDX_DATA = 4'hA;

  typedef enum logic [1:0] {
    S_IDLE,
    S_REQ,
    S_DATA,
    S_HOLD
  } seq_state_e;
endpackage

// File: rtl/dbg_rd_buf.sv
module dbg_rd_buf #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_adv_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (wr_i && wr_idx_i == PTR_W'(i)) mem_q[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_ptr_q <= '0;
    else if (clr_i) rd_ptr_q <= '0;
    else if (rd_adv_i) begin
      if (rd_ptr_q == PTR_W'(DEPTH - 1)) rd_ptr_q <= '0;
      else rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  assign rd_data_o = mem_q[rd_ptr_q];

  // R6: the host read pointer steps by one on every read of the data index
  p_rd_ptr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_adv_i && !clr_i && rd_ptr_q != PTR_W'(DEPTH - 1)) |=> rd_ptr_q == $past(rd_ptr_q) + 1'b1);
endmodule

// File: rtl/dbg_rd_seq.sv
module dbg_rd_seq
  import dbg_rd_pkg::*;
#(
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              burst_i,
  input  logic              last_i,
  input  logic              host_data_rd_i,
  input  logic              bus_gnt_i,
  input  logic              bus_rvalid_i,
  input  logic              bus_err_i,
  output logic              bus_req_o,
  output logic              beat_ok_o,
  output logic [BEAT_W-1:0] beat_idx_o,
  output logic              ready_o,
  output logic              set_dv_o,
  output logic              set_err_o,
  output logic              busy_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  seq_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              ready_q, ready_d;
  logic              take;

  assign take = (state_q == S_DATA) && bus_rvalid_i;

  always_comb begin
    state_d   = state_q;
    beat_d    = beat_q;
    ready_d   = 1'b0;
    set_dv_o  = 1'b0;
    set_err_o = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_REQ;
        beat_d  = '0;
      end
      S_REQ: if (bus_gnt_i) state_d = S_DATA;
      S_DATA: if (bus_rvalid_i) begin
        if (bus_err_i) begin
          state_d   = S_IDLE;
          set_err_o = 1'b1;
        end else if (burst_i) begin
          if (beat_q == LAST_BEAT) begin
            state_d  = S_IDLE;
            ready_d  = 1'b1;
            set_dv_o = 1'b1;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end else if (last_i) begin
          state_d  = S_IDLE;
          ready_d  = 1'b1;
          set_dv_o = 1'b1;
        end else begin
          state_d = S_HOLD;
          ready_d = 1'b1;
        end
      end
      S_HOLD: if (host_data_rd_i) state_d = S_REQ;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      beat_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      ready_q <= ready_d;
    end
  end

  assign bus_req_o  = (state_q == S_REQ) || (state_q == S_DATA);
  assign beat_ok_o  = take && !bus_err_i;
  assign beat_idx_o = beat_q;
  assign ready_o    = ready_q;
  assign busy_o     = (state_q != S_IDLE);

  // R8: request held until grant
  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_REQ && !bus_gnt_i) |=> bus_req_o);
  // R5: no request while waiting for the host
  p_hold_no_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HOLD && !host_data_rd_i) |=> !bus_req_o);
  // R6: no ready before the final burst beat
  p_burst_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && burst_i && beat_q != LAST_BEAT) |=> !ready_o);
  // R7: error beat never gives ready and drops the request
  p_err_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && bus_err_i) |=> (!ready_o && !bus_req_o));
endmodule

// File: rtl/dbg_rd_regs.sv
module dbg_rd_regs
  import dbg_rd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned HOST_W    = 32,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        reg_idx_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [HOST_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              busy_i,
  input  logic              beat_ok_i,
  input  logic              set_dv_i,
  input  logic              set_err_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic [DATA_W-1:0] buf_rdata_i,
  output logic              start_o,
  output logic              burst_o,
  output logic              last_o,
  output logic              host_data_rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        size_o
);
  localparam int unsigned CNT_LSB = 8;

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        size_q;
  logic              dv_q, err_q, burst_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] step;
  logic [CNT_W-1:0]  wr_cnt;
  logic [1:0]        wr_size;
  logic              wr_ctrl, wr_addr;

  assign wr_ctrl = reg_wr_i && (reg_idx_i == IDX_CTRL) && !busy_i;
  assign wr_addr = reg_wr_i && (reg_idx_i == IDX_ADDR) && !busy_i;
  assign wr_cnt  = reg_wdata_i[CNT_LSB +: CNT_W];
  assign wr_size = reg_wdata_i[2:1];
  assign start_o = wr_ctrl && reg_wdata_i[0];
  assign step    = ADDR_W'(1) << size_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      size_q  <= '0;
      dv_q    <= 1'b0;
      err_q   <= 1'b0;
      burst_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (wr_addr) addr_q <= reg_wdata_i[ADDR_W-1:0];
      if (wr_ctrl) begin
        cnt_q  <= wr_cnt;
        size_q <= wr_size;
      end
      if (start_o) begin
        dv_q    <= 1'b0;
        err_q   <= 1'b0;
        burst_q <= (wr_cnt == CNT_W'(BURST_LEN)) && (wr_size == 2'd3);
      end
      if (beat_ok_i) begin
        addr_q <= addr_q + step;
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        if (!burst_q) data_q <= bus_rdata_i;
      end
      if (set_dv_i)  dv_q  <= 1'b1;
      if (set_err_i) err_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_idx_i)
      IDX_CTRL: begin
        reg_rdata_o[0]                = busy_i;
        reg_rdata_o[2:1]              = size_q;
        reg_rdata_o[CNT_LSB +: CNT_W] = cnt_q;
        reg_rdata_o[16]               = dv_q;
        reg_rdata_o[17]               = err_q;
      end
      IDX_ADDR: reg_rdata_o[ADDR_W-1:0] = addr_q;
      IDX_DATA: reg_rdata_o = burst_q ? buf_rdata_i : data_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign host_data_rd_o = reg_rd_i && (reg_idx_i == IDX_DATA);
  assign burst_o        = burst_q;
  assign last_o         = (cnt_q <= CNT_W'(1));
  assign addr_o         = addr_q;
  assign size_o         = size_q;

  // R3: address steps by the access width on every completed read
  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_ok_i |=> addr_q == $past(addr_q) + $past(step));
  // R4: data-valid never set while the sequence runs
  p_dv_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !dv_q);
  // R9: host writes leave the address alone while busy
  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !beat_ok_i) |=> addr_q == $past(addr_q));
  // R7: a start clears both status bits
  p_start_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (!dv_q && !err_q));
endmodule

// File: rtl/dbg_rd_engine.sv
module dbg_rd_engine #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned HOST_W    = 32,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        reg_idx_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [HOST_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              ready_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_size_o,
  output logic              bus_burst_o,
  input  logic              bus_rvalid_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_err_i
);
  localparam int unsigned BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  logic              start, burst, last, host_data_rd, busy;
  logic              beat_ok, set_dv, set_err;
  logic [BEAT_W-1:0] beat_idx;
  logic [DATA_W-1:0] buf_rdata;

  dbg_rd_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOST_W(HOST_W),
    .CNT_W(CNT_W), .BURST_LEN(BURST_LEN)
  ) u_regs (
    .clk_i, .rst_ni, .reg_idx_i, .reg_wr_i, .reg_rd_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .beat_ok_i(beat_ok), .set_dv_i(set_dv), .set_err_i(set_err),
    .bus_rdata_i, .buf_rdata_i(buf_rdata),
    .start_o(start), .burst_o(burst), .last_o(last), .host_data_rd_o(host_data_rd),
    .addr_o(bus_addr_o), .size_o(bus_size_o)
  );

  dbg_rd_seq #(.BURST_LEN(BURST_LEN)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .burst_i(burst), .last_i(last),
    .host_data_rd_i(host_data_rd), .bus_gnt_i, .bus_rvalid_i, .bus_err_i,
    .bus_req_o, .beat_ok_o(beat_ok), .beat_idx_o(beat_idx), .ready_o,
    .set_dv_o(set_dv), .set_err_o(set_err), .busy_o(busy)
  );

  dbg_rd_buf #(.DATA_W(DATA_W), .DEPTH(BURST_LEN)) u_buf (
    .clk_i, .rst_ni, .clr_i(start), .wr_i(beat_ok && burst), .wr_idx_i(beat_idx),
    .wr_data_i(bus_rdata_i), .rd_adv_i(host_data_rd && burst && !busy),
    .rd_data_o(buf_rdata)
  );

  assign bus_burst_o = burst && busy;

  // R2: ready only ever follows an accepted beat
  p_ready_after_beat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(beat_ok));
endmodule

// File: tb/dbg_rd_engine_tb.sv
module dbg_rd_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        ready, bus_req, bus_gnt = 1'b0, bus_burst;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic        bus_rvalid = 1'b0, bus_err = 1'b0;
  logic [63:0] bus_rdata = '0;

  int n_chk = 0, n_fail = 0;
  int gnt_dly = 0, err_idx = -1, reads = 0, rdy_cnt = 0, burst_seen = 0;
  int m_phase = 0, m_cnt = 0, m_beat = 0;

  always #4 clk = ~clk;

  dbg_rd_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_idx_i(reg_idx), .reg_wr_i(reg_wr),
    .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .ready_o(ready), .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
    .bus_addr_o(bus_addr), .bus_size_o(bus_size), .bus_burst_o(bus_burst),
    .bus_rvalid_i(bus_rvalid), .bus_rdata_i(bus_rdata), .bus_err_i(bus_err)
  );

  function automatic logic [63:0] pat(logic [31:0] a);
    return {a ^ 32'h5A5A_F00F, a};
  endfunction

  // bus responder
  always @(negedge clk) begin
    bus_gnt = 1'b0; bus_rvalid = 1'b0; bus_err = 1'b0;
    case (m_phase)
      0: if (bus_req) begin m_cnt = gnt_dly; m_phase = 1; end
      1: if (m_cnt == 0) begin bus_gnt = 1'b1; m_phase = 2; m_beat = 0; end
         else m_cnt--;
      2: begin
        bus_rvalid = 1'b1;
        bus_rdata  = pat(bus_addr);
        if (bus_burst) burst_seen++;
        if (reads == err_idx) bus_err = 1'b1;
        reads++; m_beat++;
        if (bus_err || m_beat == (bus_burst ? 4 : 1)) m_phase = 3;
      end
      default: if (!bus_req) m_phase = 0;
    endcase
  end

  always @(posedge clk) begin
    #2;
    if (ready) rdy_cnt++;
  end

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [63:0] d);
    @(negedge clk);
    reg_idx = idx; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_rdy(output bit got);
    got = 1'b0;
    for (int i = 0; i < 300 && !got; i++) begin
      @(negedge clk);
      if (ready) got = 1'b1;
    end
  endtask

  function automatic logic [31:0] ctl(logic [1:0] sz, logic [7:0] cnt);
    return {16'h0, cnt, 5'h0, sz, 1'b1};
  endfunction

  // {size, count, address}
  localparam logic [41:0] VEC [6] = '{
    {2'd2, 8'd0, 32'h0000_1000},
    {2'd0, 8'd1, 32'h0000_2003},
    {2'd1, 8'd3, 32'h0000_3000},
    {2'd2, 8'd2, 32'h0000_4000},
    {2'd3, 8'd3, 32'h0000_5000},
    {2'd2, 8'd4, 32'h0000_6000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=%0d exp=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d;
    bit got;
    int  n, bytes, r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", {63'h0, ready}, 64'h0);
    chk("R1 req", {63'h0, bus_req}, 64'h0);
    #1 rst_n = 1'b1;
    rd(4'h7, d); chk("R1 ctrl", d, 64'h0);
    rd(4'h9, d); chk("R1 addr", d, 64'h0);
    // R10 unmapped index
    rd(4'h3, d); chk("R10 unmapped", d, 64'h0);

    // table walk: R2 R3 R4
    for (int v = 0; v < 6; v++) begin
      logic [1:0]  sz = VEC[v][41:40];
      logic [7:0]  cnt = VEC[v][39:32];
      logic [31:0] a = VEC[v][31:0];
      n = (cnt <= 1) ? 1 : int'(cnt);
      bytes = 1 << sz;
      wr(4'h9, a);
      wr(4'h7, ctl(sz, cnt));
      for (int i = 0; i < n; i++) begin
        wait_rdy(got);
        chk("R2 R4 ready pulse", {63'h0, got}, 64'h1);
        rd(4'h7, d);
        chk("R4 data-valid", {63'h0, d[16]}, {63'h0, (i == n - 1)});
        if (i == 0 && n > 1) begin
          // R5: hold until data fetched
          repeat (5) @(negedge clk);
          chk("R5 no req in hold", {63'h0, bus_req}, 64'h0);
        end
        rd(4'hA, d);
        chk("R2 R4 data", d, pat(a + 32'(i * bytes)));
      end
      rd(4'h9, d);
      chk("R3 address", d, {32'h0, a + 32'(n * bytes)});
      rd(4'h7, d);
      chk("R3 count zero", {56'h0, d[15:8]}, 64'h0);
    end

    // R6 burst
    rdy_cnt = 0; burst_seen = 0; gnt_dly = 1;
    wr(4'h9, 32'h8000);
    wr(4'h7, ctl(2'd3, 8'd4));
    wait_rdy(got);
    repeat (3) @(negedge clk);
    chk("R6 single ready", rdy_cnt, 1);
    chk("R6 burst beats", burst_seen, 4);
    rd(4'h7, d);
    chk("R6 dv", {63'h0, d[16]}, 64'h1);
    for (int i = 0; i < 4; i++) begin
      rd(4'hA, d);
      chk("R6 beat data", d, pat(32'h8000 + 32'(8 * i)));
    end
    rd(4'h9, d);
    chk("R6 address", d, 64'h8020);

    // R8 grant wait, R9 writes ignored while busy
    gnt_dly = 8; r0 = reads;
    wr(4'h9, 32'h9000);
    wr(4'h7, ctl(2'd2, 8'd1));
    repeat (3) @(negedge clk);
    chk("R8 req held", {63'h0, bus_req}, 64'h1);
    chk("R8 no data before grant", reads, r0);
    wr(4'h9, 32'hDEAD_0000);
    wr(4'h7, ctl(2'd0, 8'd9));
    wait_rdy(got);
    chk("R8 completes", {63'h0, got}, 64'h1);
    rd(4'hA, d);
    chk("R9 data from old addr", d, pat(32'h9000));
    rd(4'h9, d);
    chk("R9 address kept", d, 64'h9004);
    rd(4'h7, d);
    chk("R9 size kept", {62'h0, d[2:1]}, 64'h2);

    // R7 error on second read of a paced block
    gnt_dly = 0; reads = 0; err_idx = 1;
    wr(4'h9, 32'hA000);
    wr(4'h7, ctl(2'd2, 8'd3));
    wait_rdy(got);
    rd(4'hA, d);
    rdy_cnt = 0;
    repeat (20) @(negedge clk);
    chk("R7 no ready", rdy_cnt, 0);
    chk("R7 req low", {63'h0, bus_req}, 64'h0);
    rd(4'h7, d);
    chk("R7 err set", {63'h0, d[17]}, 64'h1);
    chk("R7 dv clear", {63'h0, d[16]}, 64'h0);
    rd(4'h9, d);
    chk("R7 address stop", d, 64'hA004);
    err_idx = -1; gnt_dly = 4;
    wr(4'h7, ctl(2'd2, 8'd0));
    rd(4'h7, d);
    chk("R7 start clears err", {62'h0, d[17:16]}, 64'h0);
    wait_rdy(got);
    rd(4'h7, d);
    chk("R7 R2 dv after retry", {62'h0, d[17:16]}, 64'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule